// File: doc/BRIEF.md
# Reset Cause Capture Registers

This block records why the system was last reset. Each reset source (power supply monitors, clock monitors, watchdog, external pin, power-on detector, debug and programming ports, and the core) drives one request line into the block. A reset episode is a *window*: it is the run of consecutive cycles in which at least one implemented request line is high. The block keeps two words side by side. The last-reset word is replaced at the end of each window with every cause seen during that window. The sticky word gathers causes across many windows until software clears chosen bits by writing a mask.

A small register port is used for both reads and writes. Read data is combinational from the address. Writes take effect at the next clock edge. The port is plain control with no handshake, so it has no back-pressure: every write is accepted in the cycle it is presented. A third read-only word reports which causes this instance implements. Request lines for causes that are not implemented are ignored.

Top module: `rst_cause_capture`

## Requirements
- R1: After `rst_n` is asserted, the last-reset word and the sticky word both read zero.
- R2: Address 2 reads the parameter `IMPL_MASK`, which has one bit per implemented cause. Writes to address 2 have no effect on any word.
- R3: Cause bit positions in every word are as follows. Bit 0 is low-leakage wakeup, bit 1 low-voltage detect, bit 2 loss of clock, bit 3 loss of PLL lock, bit 4 watchdog, bit 5 external pin and bit 6 power-on. Bit 8 is JTAG, bit 9 core lockup, bit 10 software request, bit 11 debug-port reset, bit 12 serial programming port reset and bit 13 stop-acknowledge error. Bits 7, 14 and 15 are never implemented.
- R4: At the first cycle with no implemented request after a window, the last-reset word (address 0) is replaced by the OR of all implemented requests seen during that window. It is visible from the next cycle. At all other times it holds its value.
- R5: Writes to address 0 are ignored.
- R6: Any implemented request sets its bit in the sticky word (address 1) from the next cycle. Bits accumulate across windows.
- R7: A write to address 1 clears the sticky bits that are set in the written mask, from the next cycle. Other sticky bits are unchanged.
- R8: When a request and a clear hit the same sticky bit in the same cycle, the bit ends up set.
- R9: A power-on request (bit 6) clears every sticky bit except the requests active in that same cycle, and sets bit 6.
- R10: Request lines of causes not in `IMPL_MASK` never set a bit in either word and do not open a window.
- R11: Read data follows `reg_addr` in the same cycle. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the always-on domain |
| rst_n | input | 1 | Asynchronous active-low initialisation of this block |
| cause_req | input | 16 | Reset request lines, one per cause bit |
| reg_addr | input | 2 | Register select: 0 last-reset, 1 sticky, 2 implemented |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 16 | Write data; a clear mask when address 1 is selected |
| reg_rdata | output | 16 | Read data of the selected register |

## Verification
The assertions check on every cycle the behaviours that hold at each edge. The last-reset word changes only at a window end, and then only to the gathered causes. A request always leaves its sticky bit set, including against a clear in the same cycle. Without a power-on request or a clear, sticky bits are never lost. A power-on request leaves only the causes active in that cycle. Unimplemented bits never show up in the last-reset word. Only the bench scenarios can show how the words are read through the port, the fixed bit positions, multi-cycle windows with overlapping sources, and that writes to the read-only words are ignored. Those scenarios run against a behavioural model.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int CAUSE_W = 16;
  localparam int ADDR_W  = 2;

  // cause bit positions
  localparam int B_WAKE   = 0;
  localparam int B_LVD    = 1;
  localparam int B_LOC    = 2;
  localparam int B_LOL    = 3;
  localparam int B_WDOG   = 4;
  localparam int B_PIN    = 5;
  localparam int B_POR    = 6;
  localparam int B_JTAG   = 8;
  localparam int B_LOCKUP = 9;
  localparam int B_SW     = 10;
  localparam int B_DBG    = 11;
  localparam int B_SPP    = 12;
  localparam int B_STOPAK = 13;

  typedef enum logic [ADDR_W-1:0] {
    A_LAST   = 2'd0,
    A_STICKY = 2'd1,
    A_IMPL   = 2'd2,
    A_NONE   = 2'd3
  } rcc_addr_e;
endpackage

// File: rtl/rcc_window.sv
module rcc_window #(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] act,
  output logic [W-1:0] last_q
);
  logic         win_q;
  logic [W-1:0] acc_q;
  logic         any_act;
  logic         win_end;

  assign any_act = |act;
  assign win_end = win_q && !any_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      acc_q  <= '0;
      last_q <= '0;
    end else begin
      win_q <= any_act;
      if (any_act) begin
        acc_q <= win_q ? (acc_q | act) : act;
      end
      if (win_end) begin
        last_q <= acc_q;
      end
    end
  end

  // R4
  last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(last_q));
  // R4
  last_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (last_q == $past(acc_q)));
  // R10
  last_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_q & ~IMPL) == '0);
endmodule

// File: rtl/rcc_sticky.sv
module rcc_sticky #(
  parameter int W = 16,
  parameter int POR_BIT = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] act,
  input  logic [W-1:0] clr,
  output logic [W-1:0] sticky_q
);
  logic [W-1:0] keep;

  // a power-on request drops all history; otherwise the clear mask applies
  assign keep = act[POR_BIT] ? '0 : (sticky_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= keep | act;
  end

  // R6 R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act != '0) |=> ((sticky_q & $past(act)) == $past(act)));
  // R7
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act[POR_BIT] && clr == '0) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
  // R9
  por_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act[POR_BIT] |=> (sticky_q[POR_BIT] && ((sticky_q & ~$past(act)) == '0)));
endmodule

// File: rtl/rcc_regport.sv
module rcc_regport
  import rcc_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      last_w,
  input  logic [W-1:0]      sticky_w,
  output logic [W-1:0]      clr,
  output logic [W-1:0]      rdata
);
  always_comb begin
    clr = '0;
    if (wr && rcc_addr_e'(addr) == A_STICKY) clr = wdata;
  end

  always_comb begin
    unique case (rcc_addr_e'(addr))
      A_LAST:   rdata = last_w;
      A_STICKY: rdata = sticky_w;
      A_IMPL:   rdata = IMPL;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/rst_cause_capture.sv
module rst_cause_capture
  import rcc_pkg::*;
#(
  parameter logic [CAUSE_W-1:0] IMPL_MASK = 16'h3F7F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CAUSE_W-1:0]  cause_req,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [CAUSE_W-1:0]  reg_wdata,
  output logic [CAUSE_W-1:0]  reg_rdata
);
  localparam logic [CAUSE_W-1:0] NEVER = (CAUSE_W'(1) << 7) | (CAUSE_W'(3) << 14);
  localparam logic [CAUSE_W-1:0] IMPL  = IMPL_MASK & ~NEVER;

  logic [CAUSE_W-1:0] act;
  logic [CAUSE_W-1:0] clr;
  logic [CAUSE_W-1:0] last_w;
  logic [CAUSE_W-1:0] sticky_w;

  assign act = cause_req & IMPL;

  rcc_window #(.W(CAUSE_W), .IMPL(IMPL)) u_win (
    .clk(clk), .rst_n(rst_n), .act(act), .last_q(last_w)
  );

  rcc_sticky #(.W(CAUSE_W), .POR_BIT(B_POR)) u_sticky (
    .clk(clk), .rst_n(rst_n), .act(act), .clr(clr), .sticky_q(sticky_w)
  );

  rcc_regport #(.W(CAUSE_W), .IMPL(IMPL)) u_port (
    .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .last_w(last_w), .sticky_w(sticky_w), .clr(clr), .rdata(reg_rdata)
  );
endmodule

// File: tb/rst_cause_capture_test.sv
module rst_cause_capture_test;
  localparam logic [15:0] IMPL = 16'h3F7F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cause_req = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int vectors = 0;
  int errors = 0;
  string req = "R1";

  // behavioural reference state
  logic [15:0] m_last = '0, m_sticky = '0, m_acc = '0;
  bit m_win = 0;

  always #2 clk = ~clk;

  rst_cause_capture uut (
    .clk(clk), .rst_n(rst_n), .cause_req(cause_req), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    logic [15:0] a;
    logic [15:0] c;
    if (!rst_n) begin
      m_last = '0; m_sticky = '0; m_acc = '0; m_win = 0;
    end else begin
      a = cause_req & IMPL;
      c = (reg_wr && reg_addr == 2'd1) ? reg_wdata : 16'h0;
      if (a[6]) m_sticky = a;
      else      m_sticky = (m_sticky & ~c) | a;
      if (a != 0) begin
        m_acc = m_win ? (m_acc | a) : a;
        m_win = 1;
      end else if (m_win) begin
        m_last = m_acc;
        m_win = 0;
      end
    end
  end

  function automatic logic [15:0] model_read(logic [1:0] ad);
    case (ad)
      2'd0: return m_last;
      2'd1: return m_sticky;
      2'd2: return IMPL;
      default: return 16'h0;
    endcase
  endfunction

  // drive at negedge, compare 1 ns later, away from the active edge
  task automatic step(input logic [15:0] cause, input logic [1:0] ad,
                      input logic wr = 1'b0, input logic [15:0] wd = 16'h0);
    logic [15:0] exp;
    @(negedge clk);
    cause_req = cause; reg_addr = ad; reg_wr = wr; reg_wdata = wd;
    #1;
    exp = model_read(ad);
    vectors++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, ad, reg_rdata, exp);
    end
  endtask

  task automatic read_all();
    for (int k = 0; k < 4; k++) step(16'h0, 2'(k));
  endtask

  task automatic expect_val(input logic [1:0] ad, input logic [15:0] v);
    step(16'h0, ad);
    vectors++;
    if (reg_rdata !== v) begin
      errors++;
      $display("FAIL %s direct addr=%0d actual=%h expected=%h", req, ad, reg_rdata, v);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    int bits[13] = '{0, 1, 2, 3, 4, 5, 6, 8, 9, 10, 11, 12, 13};
    repeat (3) @(posedge clk);
    // R1 reset state
    req = "R1";
    @(negedge clk); rst_n = 1'b1;
    expect_val(2'd0, 16'h0);
    expect_val(2'd1, 16'h0);
    // R2 parameter word, R11 unused address
    req = "R2"; expect_val(2'd2, IMPL);
    req = "R11"; expect_val(2'd3, 16'h0);
    req = "R2"; step(16'h0, 2'd2, 1'b1, 16'hFFFF); read_all();
    // R5 write to last-reset word ignored
    req = "R5"; step(16'h0, 2'd0, 1'b1, 16'hFFFF); read_all();
    // R4 R6 single watchdog pulse
    req = "R4"; step(16'h0010, 2'd0); step(16'h0, 2'd0);
    expect_val(2'd0, 16'h0010);
    req = "R6"; expect_val(2'd1, 16'h0010);
    // R4 multi-cycle overlapping window, last word holds until end
    req = "R4";
    step(16'h0002, 2'd0); step(16'h0006, 2'd0); step(16'h0004, 2'd0);
    step(16'h0, 2'd0); expect_val(2'd0, 16'h0006);
    // R6 accumulate across windows
    req = "R6"; step(16'h0020, 2'd1); step(16'h0, 2'd1);
    expect_val(2'd1, 16'h0036);
    // R7 clear by mask
    req = "R7"; step(16'h0, 2'd1, 1'b1, 16'h0012); expect_val(2'd1, 16'h0024);
    // R8 set wins over clear
    req = "R8"; step(16'h0020, 2'd1, 1'b1, 16'h0020); step(16'h0, 2'd1);
    expect_val(2'd1, 16'h0024);
    // R9 power-on wipes history
    req = "R9"; step(16'h0400, 2'd1); step(16'h0, 2'd1);
    step(16'h0041, 2'd1); step(16'h0, 2'd1);
    expect_val(2'd1, 16'h0041);
    req = "R4"; expect_val(2'd0, 16'h0041);
    // R10 unimplemented lines ignored, no window opened
    req = "R10"; step(16'hC080, 2'd0); step(16'h0, 2'd0);
    expect_val(2'd0, 16'h0041); expect_val(2'd1, 16'h0041);
    // R3 each cause lands on its own bit
    req = "R3";
    for (int i = 0; i < 13; i++) begin
      step(16'h1 << bits[i], 2'd0); step(16'h0, 2'd0);
      expect_val(2'd0, 16'h1 << bits[i]);
    end
    // mixed stretch against the model
    req = "R6";
    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step((lf[3:0] == 0) ? (lf & 16'hBFFF) : 16'h0, lf[5:4], lf[6] & lf[7], lf ^ 16'h5A5A);
    end
    read_all();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule